// File: doc/BRIEF.md
# Power-port interrupt aggregator

The block gathers event flags from four power ports and four internal sources into one interrupt request for a host processor. The request is modelled as an open-drain, active-low line: the block either pulls it low or leaves it released. Each event is latched in a sticky status register. An eight-bit enable mask decides which latched events may raise the request. The host clears every latched event by writing a clear command to a separate command register. The request line never changes while a bus transaction is open, so the host never sees it move in the middle of an access.

The host reaches the block through a simple write/read register port. This port stands in for the register side of a two-wire serial slave; the bit-level protocol sits outside. The block also presents its seven-bit bus address, built from four strap inputs.

Two kinds of asynchronous board input pass through glitch filters before they act. The first is an active-low board reset, which returns every register to its power-up value and turns all ports off. The second is one active-low shutdown input per port, which turns that port off for as long as it is held low. That has the same effect as the per-port bits of the command register, which pulse a port off for one cycle.

Top module: `pwr_irq_hub`

## Requirements
- R1: `dev_addr` equals binary 010 in bits 6:4 followed by `strap[3:0]` in bits 3:0.
- R2: Event bits are sticky. Bit k (k=0..3) latches `port_evt[k]`, bit 4+k latches `int_evt[k]`. A latched bit stays set until a clear command, and the event register reads back at address 00h.
- R3: A write to address 1Ah with bit 7 or bit 6 set clears all event bits at the next clock edge. An event that arrives in the same cycle is latched anyway. A write to 1Ah with bits 7 and 6 both zero clears nothing.
- R4: `irq_pull` (1 = drive line low) follows "any latched event AND its mask bit" with one register of delay. It loads only in cycles where `bus_active` is 0 and keeps its value in every cycle where `bus_active` is 1.
- R5: The mask register is at address 01h, bit k enables event bit k, and it resets to FFh. An event whose mask bit is 0 is still latched but does not raise `irq_pull`.
- R6: Address 1Ah reads as 00h. Writing 1 to bit k (k=0..3) of 1Ah makes `port_off[k]` high for exactly one cycle, starting one clock after the write.
- R7: A low on `shdn_n[k]` that lasts at least FILT_CYCLES (GLITCH_PS / CLK_PERIOD_PS, default 125) consecutive clock samples holds `port_off[k]` high until the input returns high. A shorter low has no effect. `port_off[k]` drops within three clocks after the input returns high.
- R8: `ext_rst_n` is filtered in the same way. While a filtered low is present, all ports are off (`port_off` = Fh), `irq_pull` is 0, and the registers hold their power-up values (events 00h, mask FFh). A shorter low pulse leaves every register unchanged.
- R9: `rst_n` is a synchronous active-low reset that puts the block into the same power-up state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_rst_n | input | 1 | Asynchronous active-low board reset, filtered |
| shdn_n | input | 4 | Asynchronous active-low per-port shutdown, filtered |
| strap | input | 4 | Low four bits of the bus address |
| port_evt | input | 4 | Per-port event pulses |
| int_evt | input | 4 | Internal event pulses |
| bus_active | input | 1 | High while a host bus transaction is open |
| wr_en | input | 1 | One-cycle register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| dev_addr | output | 7 | Bus address presented to the serial slave |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |
| port_off | output | 4 | Per-port turn-off request |

## Verification
The embedded properties check the following on every cycle:
- the interrupt output stays frozen while a transaction is open, and it rises only from an idle-bus cycle with an enabled event;
- event bits persist when no clear arrives, and a clear leaves exactly the events of that same cycle;
- the mask moves only on a write to its address;
- a port command pulse comes only from a write to the command register;
- a filter output is released after a high sample and rises only after a low one.

Only the bench scenarios can show the rest:
- the filter threshold, where FILT_CYCLES-1 samples are ignored and a longer hold acts;
- the mask reset value and the read-back of zero from the command register;
- the effect of a board reset on the register contents;
- the full sequence of mask, clear and gate interactions over a stream of events.

// File: rtl/pwr_irq_pkg.sv
// Shared constants for the power-port interrupt aggregator.
// Assumes an eight-bit register port with byte addresses.
package pwr_irq_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] ADDR_EVENTS = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_CMD    = 8'h1A;
    localparam int unsigned CLR_BIT_HI = 7;
    localparam int unsigned CLR_BIT_LO = 6;
    localparam logic [2:0]  BUS_ADDR_PREFIX = 3'b010;
endpackage

// File: rtl/pwr_irq_deglitch.sv
// Two-flop synchroniser followed by a low-pulse filter for one active-low
// asynchronous input. low_seen rises only after HOLD_CYCLES consecutive low
// synchronised samples, and it falls on the first high sample.
// Assumes HOLD_CYCLES >= 1.
module pwr_irq_deglitch #(
    parameter int unsigned HOLD_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic low_seen
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    logic             sync_a;
    logic             sync_b;
    logic [CNT_W-1:0] low_cnt;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pin_n;
            sync_b <= sync_a;
        end
    end

    // Count consecutive low samples; pass low only once the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            low_seen <= 1'b0;
        end else if (sync_b) begin
            low_cnt  <= '0;
            low_seen <= 1'b0;
        end else if (low_cnt == CNT_LAST) begin
            low_seen <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R7
    filt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_b |=> !low_seen);
    // R7
    filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_seen) |-> !$past(sync_b));
endmodule

// File: rtl/pwr_irq_regs.sv
// Host register port: mask register, command decode and read mux.
// Command bits are not stored; the per-port bits become a registered
// one-cycle pulse, and the clear bits a same-cycle strobe.
// Assumes EVT_W <= DATA_W and NUM_PORTS <= CLR_BIT_LO.
module pwr_irq_regs
    import pwr_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned EVT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [EVT_W-1:0]     evt_q,
    output logic [EVT_W-1:0]     mask_q,
    output logic                 clr_evt,
    output logic [NUM_PORTS-1:0] port_cmd_q,
    output logic [DATA_W-1:0]    rdata
);
    logic mask_we;
    logic cmd_we;

    // Decode writes by address.
    always_comb begin
        mask_we = wr_en && (addr == ADDR_MASK);
        cmd_we  = wr_en && (addr == ADDR_CMD);
        clr_evt = cmd_we && (wdata[CLR_BIT_HI] || wdata[CLR_BIT_LO]);
    end

    // Mask register, all events enabled at power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= wdata[EVT_W-1:0];
        end
    end

    // Per-port command bits become a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_cmd_q <= '0;
        end else if (cmd_we) begin
            port_cmd_q <= wdata[NUM_PORTS-1:0];
        end else begin
            port_cmd_q <= '0;
        end
    end

    // Read mux; the command register always reads as zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_EVENTS) begin
            rdata[EVT_W-1:0] = evt_q;
        end else if (addr == ADDR_MASK) begin
            rdata[EVT_W-1:0] = mask_q;
        end
    end

    // R5
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_MASK) |=> $stable(mask_q));
    // R6
    port_cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_cmd_q != '0) |-> ($past(wr_en) && $past(addr) == ADDR_CMD));
endmodule

// File: rtl/pwr_irq_events.sv
// Sticky event latch and mask combine. A clear resets all bits, but an
// event arriving in the same cycle is still latched (the event wins).
// Assumes event inputs are synchronous to clk.
module pwr_irq_events #(
    parameter int unsigned EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             clr_evt,
    input  logic [EVT_W-1:0] mask_q,
    output logic [EVT_W-1:0] evt_q,
    output logic             irq_req
);
    // Latch events; a clear keeps only this cycle's new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else if (clr_evt) begin
            evt_q <= evt_in;
        end else begin
            evt_q <= evt_q | evt_in;
        end
    end

    // Any enabled latched event requests an interrupt.
    always_comb begin
        irq_req = |(evt_q & mask_q);
    end

    // R2
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    // R3
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (evt_q == $past(evt_in)));
endmodule

// File: rtl/pwr_irq_gate.sv
// Transaction gate for the interrupt output: the registered request is
// reloaded only while no bus transaction is open, otherwise it holds.
// Assumes bus_active is synchronous to clk.
module pwr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_active,
    input  logic irq_req,
    output logic irq_pull
);
    // Update the open-drain drive only between transactions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pull <= 1'b0;
        end else if (!bus_active) begin
            irq_pull <= irq_req;
        end
    end

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |=> $stable(irq_pull));
    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> ($past(irq_req) && !$past(bus_active)));
endmodule

// File: rtl/pwr_irq_hub.sv
// Top level of the power-port interrupt aggregator. Filters the board
// reset and per-port shutdown inputs, latches and masks events, and gates
// the open-drain interrupt drive on bus idle. The core reset is the system
// reset combined with the filtered board reset.
// Assumes CLK_PERIOD_PS divides GLITCH_PS and that NUM_PORTS + NUM_INT <= 8.
module pwr_irq_hub
    import pwr_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned NUM_INT       = 4,
    parameter int unsigned STRAP_W       = 4,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned GLITCH_PS     = 1000000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ext_rst_n,
    input  logic [NUM_PORTS-1:0]   shdn_n,
    input  logic [STRAP_W-1:0]     strap,
    input  logic [NUM_PORTS-1:0]   port_evt,
    input  logic [NUM_INT-1:0]     int_evt,
    input  logic                   bus_active,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [STRAP_W+2:0]     dev_addr,
    output logic                   irq_pull,
    output logic [NUM_PORTS-1:0]   port_off
);
    localparam int unsigned FILT_CYCLES = GLITCH_PS / CLK_PERIOD_PS;
    localparam int unsigned EVT_W       = NUM_PORTS + NUM_INT;

    logic                 ext_rst_low;
    logic                 core_rst_n;
    logic [NUM_PORTS-1:0] shdn_low;
    logic [EVT_W-1:0]     evt_q;
    logic [EVT_W-1:0]     mask_q;
    logic                 clr_evt;
    logic                 irq_req;
    logic [NUM_PORTS-1:0] port_cmd_q;

    // Board reset filter runs on the system reset only.
    pwr_irq_deglitch #(.HOLD_CYCLES(FILT_CYCLES)) i_rst_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_rst_n),
        .low_seen (ext_rst_low)
    );

    // One shutdown filter per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_shdn
        pwr_irq_deglitch #(.HOLD_CYCLES(FILT_CYCLES)) i_shdn_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (shdn_n[p]),
            .low_seen (shdn_low[p])
        );
    end

    // Core reset: system reset or a filtered board reset.
    always_comb begin
        core_rst_n = rst_n && !ext_rst_low;
    end

    pwr_irq_regs #(.NUM_PORTS(NUM_PORTS), .EVT_W(EVT_W)) i_regs (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .evt_q      (evt_q),
        .mask_q     (mask_q),
        .clr_evt    (clr_evt),
        .port_cmd_q (port_cmd_q),
        .rdata      (rdata)
    );

    pwr_irq_events #(.EVT_W(EVT_W)) i_events (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .evt_in  ({int_evt, port_evt}),
        .clr_evt (clr_evt),
        .mask_q  (mask_q),
        .evt_q   (evt_q),
        .irq_req (irq_req)
    );

    pwr_irq_gate i_gate (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .bus_active (bus_active),
        .irq_req    (irq_req),
        .irq_pull   (irq_pull)
    );

    // Port turn-off: reset, held shutdown, or command pulse.
    always_comb begin
        port_off = port_cmd_q | shdn_low | {NUM_PORTS{!core_rst_n}};
    end

    // Bus address: fixed prefix followed by the straps.
    always_comb begin
        dev_addr = {BUS_ADDR_PREFIX, strap};
    end
endmodule

// File: tb/test_pwr_irq_hub.sv
`timescale 1ns/1ps
module test_pwr_irq_hub;
    localparam int FILT = 1000000 / 8000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic [3:0] shdn_n = 4'hF;
    logic [3:0] strap = 4'h0;
    logic [3:0] port_evt = 4'h0;
    logic [3:0] int_evt = 4'h0;
    logic       bus_active = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [6:0] dev_addr;
    logic       irq_pull;
    logic [3:0] port_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_irq_hub i_pwr_irq_hub (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .shdn_n(shdn_n),
        .strap(strap), .port_evt(port_evt), .int_evt(int_evt),
        .bus_active(bus_active), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dev_addr(dev_addr), .irq_pull(irq_pull),
        .port_off(port_off)
    );

    // Fields: evt[34:27] wr[26] addr[25:18] wdata[17:10] bus[9] exp_irq[8] exp_evt[7:0]
    localparam logic [34:0] VEC [16] = '{
        {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
        {8'h01, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h01},
        {8'h00, 1'b1, 8'h1A, 8'h80, 1'b1, 1'b1, 8'h00},
        {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
        {8'h00, 1'b1, 8'h01, 8'hF0, 1'b1, 1'b0, 8'h00},
        {8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h02},
        {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h12},
        {8'h20, 1'b1, 8'h1A, 8'h40, 1'b0, 1'b1, 8'h20},
        {8'h00, 1'b1, 8'h1A, 8'h40, 1'b0, 1'b0, 8'h00},
        {8'h80, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h80},
        {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h80},
        {8'h00, 1'b1, 8'h01, 8'h00, 1'b0, 1'b0, 8'h80},
        {8'h00, 1'b1, 8'h01, 8'hFF, 1'b0, 1'b1, 8'h80},
        {8'h00, 1'b1, 8'h1A, 8'hC0, 1'b0, 1'b0, 8'h00},
        {8'h04, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h04},
        {8'h00, 1'b1, 8'h1A, 8'h3F, 1'b1, 1'b1, 8'h04}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    endtask

    task automatic reg_read(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, {24'h0, rdata}, {24'h0, exp});
        addr = 8'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        reg_read("R9 events after reset", 8'h00, 8'h00);
        reg_read("R5 mask reset value", 8'h01, 8'hFF);
        chk("R9 irq after reset", {31'h0, irq_pull}, 32'h0);
        chk("R9 port_off after reset", {28'h0, port_off}, 32'h0);
        // R1 address straps
        strap = 4'h0; #1;
        chk("R1 address strap 0", {25'h0, dev_addr}, 32'h20);
        strap = 4'hA; #1;
        chk("R1 address strap A", {25'h0, dev_addr}, 32'h2A);

        // R2 R3 R4 R5 vector walk
        for (int i = 0; i < 16; i++) begin
            logic [34:0] v;
            v = VEC[i];
            @(negedge clk);
            port_evt = v[30:27]; int_evt = v[34:31];
            wr_en = v[26]; addr = v[25:18]; wdata = v[17:10]; bus_active = v[9];
            @(negedge clk);
            port_evt = 4'h0; int_evt = 4'h0; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
            #1;
            chk($sformatf("R2 R3 R5 events vec %0d", i), {24'h0, rdata}, {24'h0, v[7:0]});
            @(negedge clk);
            chk($sformatf("R4 R5 irq vec %0d", i), {31'h0, irq_pull}, {31'h0, v[8]});
        end
        bus_active = 1'b0;
        reg_write(8'h1A, 8'h80);
        repeat (2) @(negedge clk);

        // R6 command register reads zero, port pulse lasts one cycle
        reg_read("R6 command reads zero", 8'h1A, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h1A; wdata = 8'h05;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
        chk("R6 port pulse", {28'h0, port_off}, 32'h5);
        @(negedge clk);
        chk("R6 pulse ends", {28'h0, port_off}, 32'h0);

        // R7 short shutdown pulse is ignored
        shdn_n[2] = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        shdn_n[2] = 1'b1;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (port_off != 4'h0) seen = 1'b1;
            end
            chk("R7 short shutdown ignored", {31'h0, seen}, 32'h0);
        end
        // R7 long shutdown acts and releases
        shdn_n[2] = 1'b0;
        repeat (FILT + 4) @(negedge clk);
        chk("R7 long shutdown", {28'h0, port_off}, 32'h4);
        shdn_n[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 shutdown release", {28'h0, port_off}, 32'h0);

        // R8 board reset: short pulse ignored
        reg_write(8'h01, 8'h0F);
        @(negedge clk);
        port_evt = 4'h1;
        @(negedge clk);
        port_evt = 4'h0;
        @(negedge clk);
        chk("R8 irq before board reset", {31'h0, irq_pull}, 32'h1);
        ext_rst_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_read("R8 short reset keeps mask", 8'h01, 8'h0F);
        reg_read("R8 short reset keeps events", 8'h00, 8'h01);
        // R8 long board reset
        ext_rst_n = 1'b0;
        repeat (FILT + 4) @(negedge clk);
        chk("R8 ports off in reset", {28'h0, port_off}, 32'hF);
        chk("R8 irq released in reset", {31'h0, irq_pull}, 32'h0);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_read("R8 mask power-up", 8'h01, 8'hFF);
        reg_read("R8 events power-up", 8'h00, 8'h00);
        chk("R8 ports back on", {28'h0, port_off}, 32'h0);

        // R9 system reset mid-operation
        @(negedge clk);
        int_evt = 4'h8;
        @(negedge clk);
        int_evt = 4'h0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_read("R9 events cleared by reset", 8'h00, 8'h00);
        chk("R9 irq cleared by reset", {31'h0, irq_pull}, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule